// File: doc/BRIEF.md
# Ring-Systolic Matrix Multiply Array

This block computes C = C + A*B for square signed integer matrices of order P on a closed ring of P processing elements. Element i owns column i of A, B and C. A run starts with every element copying its own A column into a rotating column register. It then applies rank-1 updates to its C column, one row per cycle. Between updates, all rotating columns move one hop around the ring at the same time: element i receives from element (i-1) mod P. In phase j, element i holds A column (i-j) mod P and multiplies it by the B entry in row (i-j) mod P of its own column.

Matrices are loaded word by word through a write port that selects the matrix, the owning element (the column) and the row. A one-cycle start launches the run, and a one-cycle done marks its end. Results are fetched through a registered read port. Because the C columns are only added to, a second run with no reloading adds A*B again.

Top module: `ring_mm_array`

## Requirements
- R1: After reset, busy, done and rd_data are all 0.
- R2: While idle, wr_en writes wr_data into row wr_row of column wr_pe of the matrix chosen by wr_sel (0 = A, 1 = B, 2 = C, 3 = no write). A and B keep the low 16 bits as a signed value, and C keeps all 40 bits.
- R3: After a run, every C(r,c) equals its previous value plus the sum over k of A(r,k)*B(k,c), computed exactly in 40-bit two's complement.
- R4: A C matrix that holds nonzero values when start is given is accumulated onto, not overwritten.
- R5: done is a single-cycle pulse. It goes high P*P+P clock edges after the edge that sampled start, and busy is high from the edge after start until the edge that raises done.
- R6: While busy, start and wr_en are ignored. Neither the running result nor the stored A matrix changes because of them.
- R7: The phase index runs from 0 to P-1 and never decreases during a run. In phase j, element i uses A column (i-j) mod P and B row (i-j) mod P, so a value placed only in the last A column reaches every element.
- R8: rd_data presents C(rd_row, rd_pe) one clock edge after the address is applied.
- R9: A second start with no reloading adds A*B onto the result of the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled while idle) |
| wr_en | input | 1 | Write strobe for loading |
| wr_sel | input | 2 | Target matrix: 0 A, 1 B, 2 C |
| wr_pe | input | $clog2(P) | Target column / owning element |
| wr_row | input | $clog2(P) | Target row |
| wr_data | input | AW | Write word (low DW bits used for A and B) |
| rd_pe | input | $clog2(P) | Read column |
| rd_row | input | $clog2(P) | Read row |
| rd_data | output | AW | Registered C word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
If the rotation or the B row index is off by one hop, the fault shows up in particular C entries as products that are missing or counted twice. These become visible at the read port as soon as done arrives. A single nonzero A column placed at the far end of the ring tests the wrap in every element. A phase or row counter that stops at the wrong value changes when done fires, so the fault is caught at the end of the first run, P*P+P cycles after start. A write or start that leaks through during a run changes either the result of that run or the result of the next accumulating run.

// File: rtl/rmm_pkg.sv
package rmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_MAC   = 2'd2,
    ST_SHIFT = 2'd3
  } rmm_state_t;

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;
endpackage

// File: rtl/rmm_seq.sv
module rmm_seq
  import rmm_pkg::*;
#(
  parameter int P = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  output logic                       load,
  output logic                       mac,
  output logic                       shift,
  output logic [$clog2(P)-1:0]       row,
  output logic [$clog2(P):0]         step,
  output logic                       busy,
  output logic                       done
);
  localparam int IW = $clog2(P);
  localparam int SW = $clog2(P) + 1;

  rmm_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      row     <= '0;
      step    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_LOAD;
        ST_LOAD: begin
          state_q <= ST_MAC;
          row     <= '0;
        end
        ST_MAC: begin
          if (row == IW'(P - 1)) begin
            row <= '0;
            if (step == SW'(P - 1)) begin
              state_q <= ST_IDLE;
              step    <= '0;
              done    <= 1'b1;
            end else begin
              state_q <= ST_SHIFT;
            end
          end else begin
            row <= row + 1'b1;
          end
        end
        ST_SHIFT: begin
          step    <= step + 1'b1;
          state_q <= ST_MAC;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load  = (state_q == ST_LOAD);
  assign mac   = (state_q == ST_MAC);
  assign shift = (state_q == ST_SHIFT);
  assign busy  = (state_q != ST_IDLE);
endmodule

// File: rtl/rmm_pe.sv
module rmm_pe #(
  parameter int P   = 4,
  parameter int DW  = 16,
  parameter int AW  = 40,
  parameter int IDX = 0
) (
  input  logic                    clk,
  input  logic                    wr_a,
  input  logic                    wr_b,
  input  logic                    wr_c,
  input  logic [$clog2(P)-1:0]    wr_row,
  input  logic [AW-1:0]           wr_data,
  input  logic                    load,
  input  logic                    mac,
  input  logic                    shift,
  input  logic [$clog2(P)-1:0]    row,
  input  logic [$clog2(P):0]      step,
  input  logic [P*DW-1:0]         tmp_i,
  output logic [P*DW-1:0]         tmp_o,
  input  logic [$clog2(P)-1:0]    rd_row,
  output logic [AW-1:0]           rd_word
);
  localparam int IW = $clog2(P);
  localparam int SW = $clog2(P) + 1;
  localparam int PW = 2 * DW;

  logic [DW-1:0] a_mem [P];
  logic [DW-1:0] b_mem [P];
  logic [DW-1:0] tmp_q [P];
  logic [AW-1:0] c_mem [P];

  logic [SW:0]          bsum;
  logic [IW-1:0]        brow;
  logic signed [PW-1:0] prod;

  always_ff @(posedge clk) begin
    if (wr_a) a_mem[wr_row] <= wr_data[DW-1:0];
    if (wr_b) b_mem[wr_row] <= wr_data[DW-1:0];
  end

  // rotating column: own A column on load, upstream neighbour on shift
  always_ff @(posedge clk) begin
    for (int k = 0; k < P; k++) begin
      if (load)       tmp_q[k] <= a_mem[k];
      else if (shift) tmp_q[k] <= tmp_i[k*DW +: DW];
    end
  end

  always_comb begin
    for (int k = 0; k < P; k++) tmp_o[k*DW +: DW] = tmp_q[k];
  end

  // B row = (IDX - step) mod P via add-P then compare-and-subtract
  always_comb begin
    bsum = (SW+1)'(IDX) + (SW+1)'(P) - {1'b0, step};
    if (bsum >= (SW+1)'(P)) bsum = bsum - (SW+1)'(P);
    brow = bsum[IW-1:0];
  end

  assign prod = $signed(tmp_q[row]) * $signed(b_mem[brow]);

  always_ff @(posedge clk) begin
    if (mac)       c_mem[row]    <= c_mem[row] + {{(AW-PW){prod[PW-1]}}, prod};
    else if (wr_c) c_mem[wr_row] <= wr_data;
  end

  assign rd_word = c_mem[rd_row];
endmodule

// File: rtl/ring_mm_array.sv
module ring_mm_array
  import rmm_pkg::*;
#(
  parameter int P  = 4,
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [$clog2(P)-1:0]  wr_pe,
  input  logic [$clog2(P)-1:0]  wr_row,
  input  logic [AW-1:0]         wr_data,
  input  logic [$clog2(P)-1:0]  rd_pe,
  input  logic [$clog2(P)-1:0]  rd_row,
  output logic [AW-1:0]         rd_data,
  output logic                  busy,
  output logic                  done
);
  localparam int IW = $clog2(P);
  localparam int SW = $clog2(P) + 1;

  logic          load_w, mac_w, shift_w;
  logic [IW-1:0] row_w;
  logic [SW-1:0] step_w;
  logic          wr_ok;

  logic [P*DW-1:0] ring_bus [P];
  logic [AW-1:0]   rd_bus   [P];

  assign wr_ok = wr_en && !busy;

  rmm_seq #(.P(P)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .load(load_w), .mac(mac_w), .shift(shift_w),
    .row(row_w), .step(step_w), .busy(busy), .done(done)
  );

  for (genvar g = 0; g < P; g++) begin : g_pe
    localparam int PREV = (g == 0) ? P - 1 : g - 1;
    logic hit;
    assign hit = wr_ok && (wr_pe == IW'(g));

    rmm_pe #(.P(P), .DW(DW), .AW(AW), .IDX(g)) u_pe (
      .clk(clk),
      .wr_a(hit && wr_sel == SEL_A),
      .wr_b(hit && wr_sel == SEL_B),
      .wr_c(hit && wr_sel == SEL_C),
      .wr_row(wr_row), .wr_data(wr_data),
      .load(load_w), .mac(mac_w), .shift(shift_w),
      .row(row_w), .step(step_w),
      .tmp_i(ring_bus[PREV]), .tmp_o(ring_bus[g]),
      .rd_row(rd_row), .rd_word(rd_bus[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_bus[rd_pe];
  end
endmodule

// File: rtl/rmm_chk.sv
module rmm_chk #(
  parameter int P  = 4,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [SW-1:0] step
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R5
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> (busy || done)); // R6
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst) int'(step) < P); // R7
  AST_STEP_MONO: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> (step >= $past(step))); // R7
  AST_IDLE_STEP_ZERO: assert property (@(posedge clk) disable iff (rst) !busy |-> (step == '0)); // R7
endmodule

bind ring_mm_array rmm_chk #(.P(P), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .step(step_w)
);

// File: tb/sim_ring_mm_array.sv
module sim_ring_mm_array;
  localparam int P   = 4;
  localparam int DW  = 16;
  localparam int AW  = 40;
  localparam int IW  = $clog2(P);
  localparam int CLK = 10;

  logic clk = 0, rst = 1, start = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [IW-1:0] wr_pe = 0, wr_row = 0, rd_pe = 0, rd_row = 0;
  logic [AW-1:0] wr_data = 0, rd_data;
  logic busy, done;

  int checks = 0, failures = 0;
  bit finished = 0;
  longint a_m [P][P];
  longint b_m [P][P];
  longint c_m [P][P];

  logic [AW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_req = 0;

  ring_mm_array #(.P(P), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_pe(wr_pe), .wr_row(wr_row), .wr_data(wr_data), .rd_pe(rd_pe),
    .rd_row(rd_row), .rd_data(rd_data), .busy(busy), .done(done)
  );

  always #(CLK/2) clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries one edge after a read address was applied (R8)
  always @(posedge clk) begin
    if (rd_req) begin
      @(negedge clk);
      check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] sel, input int col, input int r, input longint v);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_pe = IW'(col); wr_row = IW'(r); wr_data = AW'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_all(input bit load_ab);
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        if (load_ab) begin
          wr(2'd0, c, r, a_m[r][c]);
          wr(2'd1, c, r, b_m[r][c]);
        end
        wr(2'd2, c, r, c_m[r][c]);
      end
  endtask

  function automatic void model_step();
    longint nc [P][P];
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        nc[r][c] = c_m[r][c];
        for (int k = 0; k < P; k++) nc[r][c] += a_m[r][k] * b_m[k][c];
      end
    c_m = nc;
  endfunction

  // driver: issue reads and push expected words into the scoreboard
  task automatic read_all(input string req);
    for (int c = 0; c < P; c++)
      for (int r = 0; r < P; r++) begin
        @(negedge clk);
        rd_pe = IW'(c); rd_row = IW'(r); rd_req = 1;
        exp_q.push_back(AW'(c_m[r][c]));
        tag_q.push_back(req);
      end
    @(negedge clk);
    rd_req = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input bit disturb);
    int n;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check("R5 busy after start", AW'(busy), 1);
    n = 0;
    while (!done && n < 1000) begin
      if (disturb && n == 2) begin // R6: start and C write during run
        start = 1; wr_en = 1; wr_sel = 2'd2; wr_pe = 0; wr_row = 0; wr_data = AW'(12345);
      end
      if (disturb && n == 3) begin // R6: A write during run
        start = 0; wr_sel = 2'd0; wr_pe = 1; wr_row = 1; wr_data = AW'(777);
      end
      if (disturb && n == 4) wr_en = 0;
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check("R5 done latency", AW'(n), AW'(P*P + P));
    check("R5 busy low with done", AW'(busy), 0);
    @(negedge clk);
    check("R5 done one cycle", AW'(done), 0);
    model_step();
  endtask

  function automatic longint rnd16();
    return longint'(shortint'($urandom_range(0, 65535)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 busy", AW'(busy), 0);
    check("R1 done", AW'(done), 0);
    check("R1 rd_data", rd_data, 0);

    // R2 R3: random A, B with zero C
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        a_m[r][c] = rnd16(); b_m[r][c] = rnd16(); c_m[r][c] = 0;
      end
    load_all(1);
    read_all("R2 loaded C");
    run(0);
    read_all("R3 random product");

    // R4: nonzero starting C
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        a_m[r][c] = rnd16(); b_m[r][c] = rnd16();
        c_m[r][c] = longint'($urandom_range(0, 2000000)) - 1000000;
      end
    load_all(1);
    run(0);
    read_all("R4 accumulate onto C");

    // R7: only last A column nonzero, B all ones: wraps to every element
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        a_m[r][c] = (c == P-1) ? longint'(r + 3) : 0;
        b_m[r][c] = 1; c_m[r][c] = 0;
      end
    load_all(1);
    run(0);
    read_all("R7 ring wrap");

    // R3: extreme operands, sign extension into 40 bits
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        a_m[r][c] = -32768; b_m[r][c] = ((r + c) % 2 == 0) ? -32768 : 32767; c_m[r][c] = 0;
      end
    load_all(1);
    run(0);
    read_all("R3 extremes");

    // R6 then R9: disturbed run, then a second run on stored A/B
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        a_m[r][c] = rnd16(); b_m[r][c] = rnd16(); c_m[r][c] = r * 10 + c;
      end
    load_all(1);
    run(1);
    read_all("R6 ignored during run");
    run(0);
    read_all("R9 second accumulate");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule